// File: doc/BRIEF.md
# RTC Periodic and Alarm Interrupt Unit

This unit sits beside a real-time clock's BCD time and calendar counters. It reads their current values and their rollover pulses, and it raises two interrupts. The periodic timer interrupt is an active-low pulse one clock wide. It repeats every second, minute, hour or day, and the period is chosen by a two-bit field. The alarm interrupt is a level. It is raised when all six time and calendar fields equal six programmed alarm registers at a one-second update. It stays up until software clears its status bit by writing a 1 to it.

Two small state machines do the work. The timer machine has the states `TMR_IDLE` and `TMR_PULSE`. A qualified rollover takes it from `TMR_IDLE` to `TMR_PULSE`. With no new qualified rollover it returns from `TMR_PULSE` to `TMR_IDLE`. A qualified rollover that arrives while it is in `TMR_PULSE` keeps it there. The alarm machine has the states `ALM_IDLE` and `ALM_PENDING`. A match at a seconds update takes it from `ALM_IDLE` to `ALM_PENDING`. It goes back to `ALM_IDLE` only on a write-1 clear that does not coincide with a new match. A flat register port with no handshake gives software access to the alarm values, the control bits and the status bits.

Top module: `rtc_event_irq`

## Requirements
- R1: After reset `irq_timer_n` is 1 and `irq_alarm` is 0, and the control register (address 8) and the status register (address 9) both read 0.
- R2: Control bit 0 enables the timer. While it is 0, `irq_timer_n` stays high whatever rollover pulses arrive.
- R3: Control bits [3:2] select the period: 0 is a second, 1 a minute, 2 an hour and 3 a day. `irq_timer_n` goes low in the cycle after the cycle in which the selected rollover pulse is high, and it ignores the other pulses.
- R4: Each timer interrupt holds `irq_timer_n` low for exactly one clock cycle.
- R5: Status bits [5:2] hold {day, hour, minute, second}, copied from the rollover pulses when a timer interrupt fires. They are not changed at any other time, and a write to the status register does not change them.
- R6: When `sec_evt` is high and all six fields equal their alarm registers, status bit 6 reads 1 from the next cycle on. The alarm registers are at addresses 0 to 5, in the order second, minute, hour, day, month, year.
- R7: A match while `sec_evt` is low does not set the alarm.
- R8: Once set, status bit 6 stays set until a status write with data bit 6 equal to 1. A status write with bit 6 equal to 0 leaves it set.
- R9: `irq_alarm` is high exactly while status bit 6 is 1 and control bit 1 (alarm enable) is 1. A match with the enable low still sets status bit 6.
- R10: Hour bit 7 is the PM flag. It takes part in the hour comparison only while `mode_12h` is 1. In 24-hour mode only hour bits [5:0] are compared.
- R11: A match with `sec_evt` high in the same cycle as a write-1 clear leaves the alarm pending.
- R12: The alarm registers and the control register read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_evt | input | 1 | One-cycle pulse at each seconds update |
| min_evt | input | 1 | One-cycle pulse at each minute rollover |
| hour_evt | input | 1 | One-cycle pulse at each hour rollover |
| day_evt | input | 1 | One-cycle pulse at each day rollover |
| mode_12h | input | 1 | 1 selects the 12-hour format with the PM flag |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD, bit 7 is the PM flag |
| cur_day | input | 8 | Current day of month, BCD |
| cur_month | input | 8 | Current month, BCD |
| cur_year | input | 8 | Current year, BCD |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_timer_n | output | 1 | Periodic interrupt, active-low pulse |
| irq_alarm | output | 1 | Alarm interrupt, active-high level |

## Verification
The hardest state to reach from the ports is a new alarm match in the very cycle that software clears the pending alarm. The stimulus task drives a matching time with `sec_evt` high and, in the same cycle, a status write with bit 6 set, so the alarm machine sees its set and clear conditions together. A second hard case is a match that must be refused because of the PM flag. The bench keeps the time inputs the same and toggles only `mode_12h` between two otherwise identical updates.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    typedef enum logic [1:0] {
        PER_SEC  = 2'd0,
        PER_MIN  = 2'd1,
        PER_HOUR = 2'd2,
        PER_DAY  = 2'd3
    } period_e;

    typedef enum logic {
        TMR_IDLE,
        TMR_PULSE
    } tmr_state_e;

    typedef enum logic {
        ALM_IDLE,
        ALM_PENDING
    } alm_state_e;

    localparam int NUM_FIELDS = 6;
    localparam int HOUR_IDX   = 2;
    localparam int NUM_EVTS   = 4;
    localparam int ALARM_BIT  = 6;
    localparam int EVT_LSB    = 2;

endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int FIELD_W = 8,
    parameter int NFIELD  = 6,
    parameter int HOUR_I  = 2
) (
    input  logic [NFIELD*FIELD_W-1:0] cur_flat,
    input  logic [NFIELD*FIELD_W-1:0] alm_flat,
    input  logic                      mode_12h,
    output logic                      match
);
    localparam logic [FIELD_W-1:0] FULL_MASK = {FIELD_W{1'b1}};
    // hour mask: 6 BCD bits always, the PM flag (top bit) only in 12-hour mode
    localparam logic [FIELD_W-1:0] HOUR_24   = FIELD_W'(8'h3F);
    localparam logic [FIELD_W-1:0] HOUR_12   = HOUR_24 | (FIELD_W'(1) << (FIELD_W-1));

    logic [NFIELD-1:0] eq;

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        logic [FIELD_W-1:0] mask;
        if (i == HOUR_I) begin : g_hour
            assign mask = mode_12h ? HOUR_12 : HOUR_24;
        end else begin : g_plain
            assign mask = FULL_MASK;
        end
        assign eq[i] = ((cur_flat[i*FIELD_W +: FIELD_W] ^ alm_flat[i*FIELD_W +: FIELD_W]) & mask) == '0;
    end

    assign match = &eq;

endmodule

// File: rtl/rtc_timer_fsm.sv
module rtc_timer_fsm
    import rtc_irq_pkg::*;
#(
    parameter int NEV = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  period_e        period,
    input  logic [NEV-1:0] evt,
    output logic           irq_n,
    output logic [NEV-1:0] evt_status
);
    tmr_state_e state_q, state_d;
    logic       fire;

    assign fire = en && evt[period];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE:  state_d = fire ? TMR_PULSE : TMR_IDLE;
            TMR_PULSE: state_d = fire ? TMR_PULSE : TMR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TMR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            TMR_IDLE:  irq_n = 1'b1;
            TMR_PULSE: irq_n = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    evt_status <= '0;
        else if (fire) evt_status <= evt;
    end

    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> irq_n);
    assert_fall_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(fire));
    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !fire) |=> irq_n);
    assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(evt_status));

endmodule

// File: rtl/rtc_alarm_fsm.sv
module rtc_alarm_fsm
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pending
);
    alm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_IDLE:    state_d = set ? ALM_PENDING : ALM_IDLE;
            ALM_PENDING: state_d = (clr && !set) ? ALM_IDLE : ALM_PENDING;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ALM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ALM_IDLE:    pending = 1'b0;
            ALM_PENDING: pending = 1'b1;
        endcase
    end

    assert_rise_needs_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(set));
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr) |=> pending);
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> pending);

endmodule

// File: rtl/rtc_event_irq.sv
module rtc_event_irq
    import rtc_irq_pkg::*;
#(
    parameter int FIELD_W = 8,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_evt,
    input  logic               min_evt,
    input  logic               hour_evt,
    input  logic               day_evt,
    input  logic               mode_12h,
    input  logic [FIELD_W-1:0] cur_sec,
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [FIELD_W-1:0] cur_day,
    input  logic [FIELD_W-1:0] cur_month,
    input  logic [FIELD_W-1:0] cur_year,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [FIELD_W-1:0] reg_wdata,
    output logic [FIELD_W-1:0] reg_rdata,
    output logic               irq_timer_n,
    output logic               irq_alarm
);
    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(9);
    localparam int                FLAT_W    = NUM_FIELDS * FIELD_W;

    logic [FIELD_W-1:0]  alm_q [NUM_FIELDS];
    logic [FIELD_W-1:0]  ctrl_q;
    logic [FLAT_W-1:0]   cur_flat, alm_flat;
    logic [NUM_EVTS-1:0] evt_vec, evt_status;
    logic                match, alarm_set, alarm_clr, pending;
    logic                timer_en, alarm_en;
    period_e             period;

    assign cur_flat = {cur_year, cur_month, cur_day, cur_hour, cur_min, cur_sec};
    assign evt_vec  = {day_evt, hour_evt, min_evt, sec_evt};

    // alarm field registers, one per time/calendar field
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_alm
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                alm_q[i] <= '0;
            else if (reg_wr && reg_addr == ADDR_W'(i))
                alm_q[i] <= reg_wdata;
        end
        assign alm_flat[i*FIELD_W +: FIELD_W] = alm_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (reg_wr && reg_addr == ADDR_CTRL)
            ctrl_q <= reg_wdata;
    end

    assign timer_en  = ctrl_q[0];
    assign alarm_en  = ctrl_q[1];
    assign period    = period_e'(ctrl_q[3:2]);
    assign alarm_clr = reg_wr && reg_addr == ADDR_STAT && reg_wdata[ALARM_BIT];
    assign alarm_set = sec_evt && match;

    rtc_alarm_cmp #(
        .FIELD_W (FIELD_W),
        .NFIELD  (NUM_FIELDS),
        .HOUR_I  (HOUR_IDX)
    ) u_cmp (
        .cur_flat (cur_flat),
        .alm_flat (alm_flat),
        .mode_12h (mode_12h),
        .match    (match)
    );

    rtc_timer_fsm #(
        .NEV (NUM_EVTS)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (timer_en),
        .period     (period),
        .evt        (evt_vec),
        .irq_n      (irq_timer_n),
        .evt_status (evt_status)
    );

    rtc_alarm_fsm u_alm (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (alarm_set),
        .clr     (alarm_clr),
        .pending (pending)
    );

    assign irq_alarm = pending && alarm_en;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata = ctrl_q;
        end else if (reg_addr == ADDR_STAT) begin
            reg_rdata[ALARM_BIT]                   = pending;
            reg_rdata[EVT_LSB +: NUM_EVTS]         = evt_status;
        end else begin
            for (int i = 0; i < NUM_FIELDS; i++)
                if (reg_addr == ADDR_W'(i)) reg_rdata = alm_q[i];
        end
    end

    assert_alarm_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_alarm && !(reg_wr && reg_addr == ADDR_CTRL)) |=> (irq_alarm || alarm_clr || $past(alarm_clr)));

endmodule

// File: tb/tb_rtc_event_irq.sv
module tb_rtc_event_irq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sec_evt, min_evt, hour_evt, day_evt, mode_12h;
    logic [7:0] cur_sec, cur_min, cur_hour, cur_day, cur_month, cur_year;
    logic       reg_wr;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       irq_timer_n, irq_alarm;

    always #4 clk = ~clk;

    rtc_event_irq dut (
        .clk(clk), .rst_n(rst_n),
        .sec_evt(sec_evt), .min_evt(min_evt), .hour_evt(hour_evt), .day_evt(day_evt),
        .mode_12h(mode_12h),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_day(cur_day), .cur_month(cur_month), .cur_year(cur_year),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_timer_n(irq_timer_n), .irq_alarm(irq_alarm)
    );

    typedef struct {
        logic  tn;
        logic  al;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    logic [7:0] m_alm [6];
    logic [7:0] m_ctrl;
    logic       m_pend;
    logic [3:0] m_stat;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares queued expectations just after each rising edge
    always begin
        @(posedge clk);
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " irq_timer_n"}, {7'd0, irq_timer_n}, {7'd0, e.tn});
            chk({e.tag, " irq_alarm"},   {7'd0, irq_alarm},   {7'd0, e.al});
        end
    end

    function automatic logic model_match();
        logic [7:0] hm;
        hm = mode_12h ? 8'hBF : 8'h3F;
        return cur_sec == m_alm[0] && cur_min == m_alm[1] && ((cur_hour ^ m_alm[2]) & hm) == 8'h00 &&
               cur_day == m_alm[3] && cur_month == m_alm[4] && cur_year == m_alm[5];
    endfunction

    task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                            logic [7:0] d, logic [7:0] mo, logic [7:0] y);
        @(negedge clk);
        cur_sec = s; cur_min = mi; cur_hour = h; cur_day = d; cur_month = mo; cur_year = y;
    endtask

    // driver: one update cycle; ev = {day,hour,min,sec}
    task automatic update(logic [3:0] ev, logic clr, string tag);
        logic fire, set;
        @(negedge clk);
        {day_evt, hour_evt, min_evt, sec_evt} = ev;
        if (clr) begin
            reg_wr = 1'b1; reg_addr = 4'd9; reg_wdata = 8'h40;
        end
        fire = m_ctrl[0] && ev[m_ctrl[3:2]];
        set  = ev[0] && model_match();
        if (fire) m_stat = ev;
        if (clr && !set) m_pend = 1'b0;
        if (set) m_pend = 1'b1;
        q.push_back('{tn: !fire, al: m_pend && m_ctrl[1], tag: tag});
        @(negedge clk);
        {day_evt, hour_evt, min_evt, sec_evt} = 4'd0;
        reg_wr = 1'b0;
        q.push_back('{tn: 1'b1, al: m_pend && m_ctrl[1], tag: {tag, " after"}});
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        if (a < 4'd6) m_alm[a] = d;
        if (a == 4'd8) m_ctrl = d;
        if (a == 4'd9 && d[6]) m_pend = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    function automatic logic [7:0] stat_exp();
        return {1'b0, m_pend, m_stat, 2'b00};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        {sec_evt, min_evt, hour_evt, day_evt} = '0;
        mode_12h = 1'b1;
        {cur_sec, cur_min, cur_hour, cur_day, cur_month, cur_year} = '0;
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        for (int i = 0; i < 6; i++) m_alm[i] = 8'h00;
        m_ctrl = 8'h00; m_pend = 1'b0; m_stat = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 irq_timer_n", {7'd0, irq_timer_n}, 8'h01);
        chk("R1 irq_alarm",   {7'd0, irq_alarm},   8'h00);
        rd(4'd8, 8'h00, "R1 ctrl");
        rd(4'd9, 8'h00, "R1 status");

        // park the alarm on an unreachable year so timer tests see no match
        wr(4'd5, 8'h99);
        set_time(8'h10, 8'h20, 8'h03, 8'h01, 8'h01, 8'h24);

        // R2 timer disabled
        update(4'b0001, 1'b0, "R2 disabled sec");
        update(4'b1111, 1'b0, "R2 disabled day");
        rd(4'd9, stat_exp(), "R2 status untouched");

        // R3 R4 R5 period = second
        wr(4'd8, 8'h01);
        update(4'b0001, 1'b0, "R3 R4 per sec");
        rd(4'd9, stat_exp(), "R5 status sec");
        // period = minute
        wr(4'd8, 8'h05);
        update(4'b0001, 1'b0, "R3 per min sec only");
        rd(4'd9, stat_exp(), "R5 held on no fire");
        update(4'b0011, 1'b0, "R3 per min rollover");
        rd(4'd9, stat_exp(), "R5 status min");
        // period = hour
        wr(4'd8, 8'h09);
        update(4'b0011, 1'b0, "R3 per hour min only");
        update(4'b0111, 1'b0, "R3 per hour rollover");
        rd(4'd9, stat_exp(), "R5 status hour");
        // period = day
        wr(4'd8, 8'h0D);
        update(4'b0111, 1'b0, "R3 per day hour only");
        update(4'b1111, 1'b0, "R3 per day rollover");
        rd(4'd9, stat_exp(), "R5 status day");
        wr(4'd9, 8'h3C);
        rd(4'd9, stat_exp(), "R5 status write ignored");

        // R12 alarm register readback
        wr(4'd0, 8'h30); wr(4'd1, 8'h45); wr(4'd2, 8'h87);
        wr(4'd3, 8'h15); wr(4'd4, 8'h06); wr(4'd5, 8'h24);
        for (int i = 0; i < 6; i++) rd(4'(i), m_alm[i], "R12 alarm readback");
        wr(4'd8, 8'h0F);
        rd(4'd8, 8'h0F, "R12 ctrl readback");

        // R6 R7 alarm matching (12-hour mode, PM 7 o'clock)
        set_time(8'h29, 8'h45, 8'h87, 8'h15, 8'h06, 8'h24);
        update(4'b0001, 1'b0, "R6 mismatch seconds");
        set_time(8'h30, 8'h45, 8'h87, 8'h15, 8'h06, 8'h24);
        update(4'b0000, 1'b0, "R7 match without sec_evt");
        rd(4'd9, stat_exp(), "R7 status no alarm");
        update(4'b0001, 1'b0, "R6 R9 match");
        rd(4'd9, stat_exp(), "R6 status alarm set");

        // R8 sticky until write-1
        set_time(8'h31, 8'h45, 8'h87, 8'h15, 8'h06, 8'h24);
        update(4'b0001, 1'b0, "R8 stays pending");
        wr(4'd9, 8'h3C);
        rd(4'd9, stat_exp(), "R8 write 0 keeps");
        wr(4'd9, 8'h40);
        rd(4'd9, stat_exp(), "R8 write 1 clears");
        #1 chk("R8 irq_alarm low", {7'd0, irq_alarm}, 8'h00);

        // R9 enable gates the output only
        wr(4'd8, 8'h0D);
        set_time(8'h30, 8'h45, 8'h87, 8'h15, 8'h06, 8'h24);
        update(4'b0001, 1'b0, "R9 disabled match");
        rd(4'd9, stat_exp(), "R9 status set while disabled");
        wr(4'd8, 8'h0F);
        #1 chk("R9 irq after enable", {7'd0, irq_alarm}, 8'h01);
        wr(4'd9, 8'h40);

        // R10 PM flag only in 12-hour mode
        set_time(8'h30, 8'h45, 8'h07, 8'h15, 8'h06, 8'h24);
        update(4'b0001, 1'b0, "R10 12h AM vs PM");
        mode_12h = 1'b0;
        update(4'b0001, 1'b0, "R10 24h ignores flag");
        rd(4'd9, stat_exp(), "R10 status");
        wr(4'd9, 8'h40);

        // R11 new match and clear in one cycle
        update(4'b0001, 1'b0, "R11 first match");
        update(4'b0001, 1'b1, "R11 set beats clear");
        rd(4'd9, stat_exp(), "R11 status");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule